// File: doc/BRIEF.md
# Multi-Queue Word FIFO Manager

This block keeps sixty-four independent 32-bit FIFOs inside one shared buffer RAM. Each queue owns a fixed slot of the RAM, and its usable length can be set at run time. Software works through a register bus with a write channel and a read channel that may both be active in the same cycle. A write to a queue's access address pushes one word. A read of that address pops the head word, which appears on the read data port one cycle later.

From its occupancy, each queue derives four level flags: empty, nearly empty, nearly full and full. Two 3-bit logarithmic watermark codes set the nearly-empty and nearly-full thresholds. The lower half of the queues reports all four flags, packed four bits per queue, and also keeps sticky underflow and overflow flags that software clears by writing ones. The upper half reports only nearly-empty and full, one bit per queue, in two separate words.

Top module: `mq_fifo_mgr`

## Requirements
- R1: A write to access address q (0x000 + q) while queue q holds fewer entries than its length stores the word at the tail and raises the occupancy by one.
- R2: A read of access address q pops the head entry in first-in-first-out order. The word is on rd_data from the clock edge that follows the cycle in which rd_en is high, and it is held until the next read.
- R3: A pop from an empty queue returns zero and leaves the queue unchanged. For queues 0 to 31 it also sets the sticky underflow flag.
- R4: A push to a full queue (with no pop of that queue in the same cycle) discards the word. For queues 0 to 31 it also sets the sticky overflow flag.
- R5: A watermark code c maps to a threshold of 0 when c is 0, and to 2^(c-1) entries otherwise (so code 7 gives 64). A queue is nearly empty while its occupancy is at or below the nearly-empty threshold.
- R6: A queue is nearly full while its free space (length minus occupancy) is at or below the nearly-full threshold.
- R7: The status words at 0x080 to 0x083 hold queues 0 to 31, eight queues to a word. Queue q sits in word q>>3 at bit (q&7)*4, with bit 0 empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full.
- R8: The sticky words at 0x084 and 0x085 hold queues 0 to 31 at bit (q&15)*2, with bit 0 underflow and bit 1 overflow. Writing 1 clears a bit. A flag event in the same cycle as a clear leaves the flag set.
- R9: Word 0x086 holds the nearly-empty bit and word 0x087 the full bit of queues 32 to 63, with queue q at bit q-32. These queues keep no sticky flags.
- R10: When a push and a pop of the same queue fall in one cycle, the pop sees the occupancy from before that cycle. The push is accepted if the queue is not full or if the pop succeeds.
- R11: A write to config address 0x040 + q sets the length from bits 4:0, the nearly-empty code from bits 10:8 and the nearly-full code from bits 14:12. A length of 0 or one above 16 becomes 16. The write empties the queue, and reading the address returns the stored fields.
- R12: After reset every queue is empty with length 16 and both codes 0, all sticky flags are clear, and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
Two pairs of events can land in the same cycle. The first is a push and a pop of the same queue, issued together on the two channels. The bench provokes it once against an empty queue, where the pop must return zero and the pushed word must survive. It provokes it again against a full queue, where the head must come back and the pushed word must be kept without any overflow flag. The second pair is an underflow and a software clear of that same sticky bit in the same cycle. The bench judges it by reading the sticky word afterwards, which must still show the flag set.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Fixed word-address map of the register bus
    localparam int          ADDR_W     = 9;
    localparam logic [2:0]  REGION_ACC = 3'b000;   // 0x000..0x03F
    localparam logic [2:0]  REGION_CFG = 3'b001;   // 0x040..0x07F
    localparam logic [5:0]  STAT_BLK   = 6'h10;    // 0x080..0x087

    // Config word field positions
    localparam int CFG_NE_LSB = 8;
    localparam int CFG_NF_LSB = 12;

    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qflags_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } qsticky_t;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_ACC  = 2'd1,
        RD_REG  = 2'd2
    } rd_kind_e;

    // Logarithmic watermark: 0 -> 0, c -> 2^(c-1)
    function automatic logic [6:0] wm_thresh(input logic [2:0] code);
        logic [6:0] t;
        if (code == 3'd0) t = 7'd0;
        else              t = 7'd1 << (code - 3'd1);
        return t;
    endfunction

endpackage

// File: rtl/mq_buffer.sv
module mq_buffer #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1024,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/mq_queue_ctrl.sv
module mq_queue_ctrl
    import mq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter bit HAS_STICKY = 1'b1,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_len,
    input  logic [2:0]       cfg_ne,
    input  logic [2:0]       cfg_nf,
    input  logic             push,
    input  logic             pop,
    input  logic             clr_unf,
    input  logic             clr_ovf,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] len,
    output logic [2:0]       ne_code,
    output logic [2:0]       nf_code,
    output qflags_t          flags,
    output qsticky_t         sticky
);

    logic             is_full;
    logic             underflow_ev;
    logic             overflow_ev;
    logic [7:0]       cnt_ext;
    logic [7:0]       free_ext;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] l);
        logic [PTR_W-1:0] n;
        if ({1'b0, p} == CNT_W'(l - CNT_W'(1))) n = '0;
        else                                    n = p + PTR_W'(1);
        return n;
    endfunction

    assign is_full      = (count == len);
    assign pop_ok       = pop && !cfg_we && (count != '0);
    assign push_ok      = push && !cfg_we && (!is_full || pop_ok);
    assign underflow_ev = pop && !cfg_we && (count == '0);
    assign overflow_ev  = push && !cfg_we && is_full && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            len     <= CNT_W'(DEPTH);
            ne_code <= 3'd0;
            nf_code <= 3'd0;
        end else if (cfg_we) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            len     <= cfg_len;
            ne_code <= cfg_ne;
            nf_code <= cfg_nf;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr, len);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr, len);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Sticky flags: a new event outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
        end else begin
            sticky.unf <= HAS_STICKY && ((sticky.unf && !clr_unf) || underflow_ev);
            sticky.ovf <= HAS_STICKY && ((sticky.ovf && !clr_ovf) || overflow_ev);
        end
    end

    assign cnt_ext  = 8'(count);
    assign free_ext = 8'(len - count);

    always_comb begin
        flags.empty  = (count == '0);
        flags.full   = is_full;
        flags.nempty = (cnt_ext  <= {1'b0, wm_thresh(ne_code)});
        flags.nfull  = (free_ext <= {1'b0, wm_thresh(nf_code)});
    end

endmodule

// File: rtl/mq_status_pack.sv
module mq_status_pack
    import mq_pkg::*;
#(
    parameter int NUM_Q    = 64,
    parameter int DATA_W   = 32,
    localparam int HALF    = NUM_Q / 2,
    localparam int LO_WRDS = HALF / 8,
    localparam int STK_WRDS = HALF / 16
) (
    input  qflags_t  [NUM_Q-1:0]                flags,
    input  qsticky_t [NUM_Q-1:0]                sticky,
    output logic     [LO_WRDS-1:0][DATA_W-1:0]  stat_lo,
    output logic     [STK_WRDS-1:0][DATA_W-1:0] stat_stk,
    output logic     [HALF-1:0]                 up_ne,
    output logic     [HALF-1:0]                 up_full
);

    for (genvar q = 0; q < HALF; q++) begin : g_lo
        assign stat_lo[q / 8][(q % 8) * 4 +: 4]   = flags[q];
        assign stat_stk[q / 16][(q % 16) * 2 +: 2] = sticky[q];
    end

    for (genvar q = HALF; q < NUM_Q; q++) begin : g_up
        assign up_ne[q - HALF]   = flags[q].nempty;
        assign up_full[q - HALF] = flags[q].full;
    end

endmodule

// File: rtl/mq_fifo_mgr.sv
module mq_fifo_mgr
    import mq_pkg::*;
#(
    parameter int NUM_Q  = 64,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [8:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [8:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int Q_W      = $clog2(NUM_Q);
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int WORDS    = NUM_Q * DEPTH;
    localparam int AW       = Q_W + PTR_W;
    localparam int HALF     = NUM_Q / 2;
    localparam int LO_WRDS  = HALF / 8;
    localparam int STK_WRDS = HALF / 16;

    // Address decode
    logic           wr_acc, wr_cfg, rd_acc, rd_cfg, rd_stat;
    logic [Q_W-1:0] wr_q, rd_q;

    assign wr_q    = wr_addr[Q_W-1:0];
    assign rd_q    = rd_addr[Q_W-1:0];
    assign wr_acc  = wr_en && (wr_addr[8:6] == REGION_ACC);
    assign wr_cfg  = wr_en && (wr_addr[8:6] == REGION_CFG);
    assign rd_acc  = rd_en && (rd_addr[8:6] == REGION_ACC);
    assign rd_cfg  = rd_en && (rd_addr[8:6] == REGION_CFG);
    assign rd_stat = rd_en && (rd_addr[8:3] == STAT_BLK);

    // Clamp written length
    logic [CNT_W-1:0] cfg_len_c;
    always_comb begin
        cfg_len_c = wr_data[CNT_W-1:0];
        if (cfg_len_c == '0 || cfg_len_c > CNT_W'(DEPTH)) cfg_len_c = CNT_W'(DEPTH);
    end

    // Per-queue state
    logic     [NUM_Q-1:0]            push_ok, pop_ok;
    logic     [NUM_Q-1:0][PTR_W-1:0] wr_ptr, rd_ptr;
    logic     [NUM_Q-1:0][CNT_W-1:0] cnt_q, len_q;
    logic     [NUM_Q-1:0][2:0]       ne_q, nf_q;
    qflags_t  [NUM_Q-1:0]            flags;
    qsticky_t [NUM_Q-1:0]            sticky;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        localparam bit          LOWER  = (i < HALF);
        localparam logic [8:0]  STK_AD = {STAT_BLK, 3'(4 + (i % HALF) / 16)};
        logic clr_u, clr_o;

        assign clr_u = LOWER && wr_en && (wr_addr == STK_AD) && wr_data[(i % 16) * 2];
        assign clr_o = LOWER && wr_en && (wr_addr == STK_AD) && wr_data[(i % 16) * 2 + 1];

        mq_queue_ctrl #(
            .DEPTH      (DEPTH),
            .HAS_STICKY (LOWER)
        ) ctrl_i (
            .clk     (clk),
            .rst     (rst),
            .cfg_we  (wr_cfg && (wr_q == Q_W'(i))),
            .cfg_len (cfg_len_c),
            .cfg_ne  (wr_data[CFG_NE_LSB +: 3]),
            .cfg_nf  (wr_data[CFG_NF_LSB +: 3]),
            .push    (wr_acc && (wr_q == Q_W'(i))),
            .pop     (rd_acc && (rd_q == Q_W'(i))),
            .clr_unf (clr_u),
            .clr_ovf (clr_o),
            .push_ok (push_ok[i]),
            .pop_ok  (pop_ok[i]),
            .wr_ptr  (wr_ptr[i]),
            .rd_ptr  (rd_ptr[i]),
            .count   (cnt_q[i]),
            .len     (len_q[i]),
            .ne_code (ne_q[i]),
            .nf_code (nf_q[i]),
            .flags   (flags[i]),
            .sticky  (sticky[i])
        );
    end

    // Shared buffer: queue q owns words q*DEPTH .. q*DEPTH+DEPTH-1
    logic [DATA_W-1:0] ram_q;

    mq_buffer #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) buf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (|push_ok),
        .waddr (AW'({wr_q, wr_ptr[wr_q]})),
        .wdata (wr_data),
        .re    (|pop_ok),
        .raddr (AW'({rd_q, rd_ptr[rd_q]})),
        .rdata (ram_q)
    );

    // Status packing
    logic [LO_WRDS-1:0][DATA_W-1:0]  stat_lo;
    logic [STK_WRDS-1:0][DATA_W-1:0] stat_stk;
    logic [HALF-1:0]                 up_ne, up_full;

    mq_status_pack #(
        .NUM_Q  (NUM_Q),
        .DATA_W (DATA_W)
    ) pack_i (
        .flags    (flags),
        .sticky   (sticky),
        .stat_lo  (stat_lo),
        .stat_stk (stat_stk),
        .up_ne    (up_ne),
        .up_full  (up_full)
    );

    // Register read value
    logic [DATA_W-1:0] rd_val_c;
    always_comb begin
        rd_val_c = '0;
        if (rd_cfg) begin
            rd_val_c[CNT_W-1:0]          = len_q[rd_q];
            rd_val_c[CFG_NE_LSB +: 3]    = ne_q[rd_q];
            rd_val_c[CFG_NF_LSB +: 3]    = nf_q[rd_q];
        end else if (rd_stat) begin
            case (rd_addr[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: rd_val_c = stat_lo[rd_addr[1:0]];
                3'd4, 3'd5:             rd_val_c = stat_stk[rd_addr[0]];
                3'd6:                   rd_val_c = DATA_W'(up_ne);
                default:                rd_val_c = DATA_W'(up_full);
            endcase
        end
    end

    rd_kind_e          rd_kind;
    logic [DATA_W-1:0] reg_val;
    logic              pop_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_kind <= RD_NONE;
            reg_val <= '0;
            pop_hit <= 1'b0;
        end else if (rd_en) begin
            rd_kind <= rd_acc ? RD_ACC : RD_REG;
            reg_val <= rd_val_c;
            pop_hit <= |pop_ok;
        end
    end

    assign rd_data = (rd_kind == RD_ACC) ? (pop_hit ? ram_q : '0) : reg_val;

endmodule

// File: rtl/mq_fifo_mgr_chk.sv
module mq_fifo_mgr_chk #(
    parameter int NUM_Q  = 64,
    parameter int CNT_W  = 5,
    parameter int DATA_W = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [8:0]                  wr_addr,
    input logic                        rd_en,
    input logic [8:0]                  rd_addr,
    input logic [DATA_W-1:0]           rd_data,
    input logic [NUM_Q-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_Q-1:0][CNT_W-1:0] len_q
);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
        logic push_g, pop_g;
        assign push_g = wr_en && (wr_addr == 9'(g));
        assign pop_g  = rd_en && (rd_addr == 9'(g));

        // R1
        push_inc_chk: assert property (@(posedge clk) disable iff (rst)
            (push_g && !pop_g && (cnt_q[g] < len_q[g]))
            |=> (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));

        // R3
        empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (pop_g && (cnt_q[g] == '0)) |=> (rd_data == '0));

        // R4
        occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= len_q[g]);

        // R4
        full_push_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (push_g && !pop_g && (cnt_q[g] == len_q[g]))
            |=> (cnt_q[g] == $past(cnt_q[g])));

        // R12
        reset_empty_chk: assert property (@(posedge clk)
            rst |=> (cnt_q[g] == '0));
    end

endmodule

bind mq_fifo_mgr mq_fifo_mgr_chk #(
    .NUM_Q  (NUM_Q),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt_q   (cnt_q),
    .len_q   (len_q)
);

// File: tb/mq_fifo_mgr_tb.sv
module mq_fifo_mgr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [8:0]  wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    mq_fifo_mgr dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // {is_read, addr, data, expected}
    localparam int NV = 52;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 9'h043, 32'h0000_1104, 32'h0},          // q3: len 4, ne code 1, nf code 1
        {1'b1, 9'h080, 32'h0, 32'h3333_3333},          // R5 R7 empty
        {1'b0, 9'h003, 32'h0000_00A1, 32'h0},          // R1
        {1'b1, 9'h080, 32'h0, 32'h3333_2333},          // R5 count1 <= 1
        {1'b0, 9'h003, 32'h0000_00A2, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h3333_0333},          // R5 R6 mid
        {1'b0, 9'h003, 32'h0000_00A3, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h3333_4333},          // R6 free 1
        {1'b0, 9'h003, 32'h0000_00A4, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h3333_C333},          // R6 R7 full
        {1'b0, 9'h003, 32'h0000_00A5, 32'h0},          // R4 dropped
        {1'b1, 9'h084, 32'h0, 32'h0000_0080},          // R4 overflow
        {1'b1, 9'h003, 32'h0, 32'h0000_00A1},          // R2
        {1'b1, 9'h003, 32'h0, 32'h0000_00A2},
        {1'b1, 9'h003, 32'h0, 32'h0000_00A3},
        {1'b1, 9'h003, 32'h0, 32'h0000_00A4},          // R4 A5 absent
        {1'b1, 9'h003, 32'h0, 32'h0000_0000},          // R3 empty pop
        {1'b1, 9'h084, 32'h0, 32'h0000_00C0},          // R3 underflow
        {1'b0, 9'h084, 32'h0000_0080, 32'h0},          // R8 clear ovf
        {1'b1, 9'h084, 32'h0, 32'h0000_0040},
        {1'b0, 9'h084, 32'h0000_0040, 32'h0},
        {1'b1, 9'h084, 32'h0, 32'h0000_0000},          // R8
        {1'b0, 9'h003, 32'h0000_00B1, 32'h0},          // pointer wrap
        {1'b1, 9'h003, 32'h0, 32'h0000_00B1},          // R2
        {1'b1, 9'h043, 32'h0, 32'h0000_1104},          // R11 readback
        {1'b0, 9'h068, 32'h0000_0002, 32'h0},          // q40 len 2
        {1'b1, 9'h086, 32'h0, 32'hFFFF_FFFF},          // R9
        {1'b1, 9'h087, 32'h0, 32'h0000_0000},          // R9
        {1'b0, 9'h028, 32'h0000_0011, 32'h0},
        {1'b0, 9'h028, 32'h0000_0022, 32'h0},
        {1'b1, 9'h087, 32'h0, 32'h0000_0100},          // R9 q40 full
        {1'b1, 9'h086, 32'h0, 32'hFFFF_FEFF},          // R9
        {1'b1, 9'h028, 32'h0, 32'h0000_0011},
        {1'b1, 9'h028, 32'h0, 32'h0000_0022},
        {1'b1, 9'h028, 32'h0, 32'h0000_0000},          // R3 upper
        {1'b1, 9'h085, 32'h0, 32'h0000_0000},          // R9 no sticky upper
        {1'b0, 9'h045, 32'h0000_0310, 32'h0},          // q5 len 16, ne code 3
        {1'b1, 9'h045, 32'h0, 32'h0000_0310},          // R11
        {1'b0, 9'h005, 32'h1, 32'h0},
        {1'b0, 9'h005, 32'h2, 32'h0},
        {1'b0, 9'h005, 32'h3, 32'h0},
        {1'b0, 9'h005, 32'h4, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h3323_3333},          // R5 4 <= 4
        {1'b0, 9'h005, 32'h5, 32'h0},
        {1'b1, 9'h080, 32'h0, 32'h3303_3333},          // R5 5 > 4
        {1'b0, 9'h045, 32'h0000_0020, 32'h0},          // R11 length 0 clamps, flush
        {1'b1, 9'h045, 32'h0, 32'h0000_0010},          // R11
        {1'b1, 9'h080, 32'h0, 32'h3333_3333},          // R11 flushed
        {1'b1, 9'h005, 32'h0, 32'h0000_0000},          // R3
        {1'b1, 9'h084, 32'h0, 32'h0000_0400},          // R3 q5 underflow
        {1'b0, 9'h084, 32'h0000_0400, 32'h0},
        {1'b1, 9'h084, 32'h0, 32'h0000_0000}           // R8
    };

    function automatic string tag_of(input logic [8:0] a);
        if (a[8:6] == 3'b000) return "R2";
        if (a[8:6] == 3'b001) return "R11";
        if (a == 9'h084 || a == 9'h085) return "R8";
        if (a == 9'h086 || a == 9'h087) return "R9";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic do_both(input logic [8:0] wa, input logic [31:0] d,
                           input logic [8:0] ra, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = d;
        rd_en = 1'b1; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic run_all();
        logic [31:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12 rd_data", rd_data, 32'h0);
        do_rd(9'h043, v); check("R12 cfg", v, 32'h0000_0010);
        do_rd(9'h084, v); check("R12 sticky", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][73]) begin
                do_rd(VEC[i][72:64], v);
                check(tag_of(VEC[i][72:64]), v, VEC[i][31:0]);
            end else begin
                do_wr(VEC[i][72:64], VEC[i][63:32]);
            end
        end

        // R10 push+pop on empty q3
        do_both(9'h003, 32'hC1, 9'h003, v); check("R10 empty pop", v, 32'h0);
        do_rd(9'h084, v); check("R10 underflow", v, 32'h40);
        do_rd(9'h003, v); check("R10 push kept", v, 32'hC1);
        do_wr(9'h084, 32'h40);
        // R10 push+pop on full q3
        for (int k = 1; k <= 4; k++) do_wr(9'h003, 32'hE0 + k);
        do_both(9'h003, 32'hE5, 9'h003, v); check("R10 full pop", v, 32'hE1);
        do_rd(9'h084, v); check("R10 no overflow", v, 32'h0);
        for (int k = 2; k <= 5; k++) begin
            do_rd(9'h003, v); check("R10 order", v, 32'hE0 + k);
        end
        // R8 underflow and clear together
        do_both(9'h084, 32'h40, 9'h003, v); check("R8 pop zero", v, 32'h0);
        do_rd(9'h084, v); check("R8 set wins", v, 32'h40);

        // R12 reset mid-run
        do_wr(9'h003, 32'h77);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 rd_data", rd_data, 32'h0);
        do_rd(9'h080, v); check("R12 status", v, 32'h3333_3333);
        do_rd(9'h043, v); check("R12 cfg", v, 32'h0000_0010);
        do_rd(9'h084, v); check("R12 sticky", v, 32'h0);
    endtask

    initial begin
        wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        rst = 1'b1;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule